// File: doc/BRIEF.md
# Open-Load and Thermal Error Reporter

This block sits beside sixteen constant-current sink channels and turns raw analog indications into one error signal and a readable status snapshot. For each channel it takes the digital switch-on command and the output of a low-voltage comparator. It also takes an over-temperature indication and the blank control. A channel counts as open only after it has been switched on for a settling window and its comparator still reports a low output voltage. Each channel's window is longer than the one before it by a fixed stagger, which matches the staggered turn-on of the drivers.

The error output is an active-low enable for an external open-drain pull-down. It is asserted when the over-temperature flag is set, or when any qualified open-load flag is set and blank is low. Blank masks open-load faults only, so thermal faults can be told apart from open-load faults. A plain logic-level copy of the error is provided as well. On the falling edge of the latch strobe, the per-channel open flags and the thermal flag are copied into a status snapshot that a serial readout path can shift out.

The comparator vector and the temperature input are asynchronous, so each passes through a two-flop synchroniser. The switch-on commands and blank come from the same clock domain and are used directly.

Top module: `fault_reporter`

## Requirements
- R1: While reset is high, and on the first cycle after it, err_flag is 0, err_oe_n is 1, status_open is all zeros and status_hot is 0.
- R2: Bit i of ch_on and ch_low belongs to channel i. Channel 0 has ch_low held high for at least 3 cycles and ch_on is raised. err_flag then rises exactly SETTLE_CYC+2 clock edges after the first edge that samples ch_on high, and not earlier.
- R3: A channel raises no error unless it is both switched on and reporting low. Channels that are low but off, or on but not low, leave err_flag at 0.
- R4: Switching a qualified channel off makes err_flag fall 2 edges later. Switching it back on restarts the full qualification window.
- R5: The thermal fault is not latched. err_flag rises 3 edges after hot_in rises and falls 3 edges after hot_in falls, whatever the channel inputs are.
- R6: While blank is 1, qualified open-load flags do not reach err_flag (the effect shows one edge after blank rises). A thermal fault still sets err_flag.
- R7: On the first edge that samples latch_strobe low after it was high, status_open receives the qualified open flags (bit i = channel i, whatever blank is) and status_hot receives the synchronised thermal flag. A rising strobe, or a strobe held at a steady level, leaves both unchanged.
- R8: The qualification window of channel i is SETTLE_CYC + i*STAGGER_CYC cycles. Channel 15 raises err_flag exactly SETTLE_CYC+15*STAGGER_CYC+2 edges after it is switched on.
- R9: err_oe_n is 0 (pull-down enabled) exactly when err_flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_on | input | NUM_CH | Per-channel switch-on command, bit i = channel i |
| ch_low | input | NUM_CH | Per-channel low-voltage comparator output (asynchronous) |
| hot_in | input | 1 | Over-temperature indication (asynchronous) |
| blank | input | 1 | Masks open-load faults from the error output |
| latch_strobe | input | 1 | Capture strobe; its falling edge loads the snapshot |
| err_oe_n | output | 1 | Active-low enable of the open-drain error pull-down |
| err_flag | output | 1 | Logic-level error, 1 = fault present |
| status_open | output | NUM_CH | Captured open-load flags |
| status_hot | output | 1 | Captured thermal flag |

## Verification
The assertions assume that reset is applied before ch_on or latch_strobe move, and that ch_on stays in the clock domain, so a rising edge of ch_on always finds the channel's timer reloaded. They also assume SETTLE_CYC is at least 1, so that no flag can appear on the edge that first sees a channel on. The stimulus changes every input on the falling clock edge, keeps ch_low steady for several cycles before it times a window, and keeps the strobe low through reset.

// File: rtl/fr_pkg.sv
package fr_pkg;
  // Qualification length for one channel: base settling plus its turn-on stagger.
  function automatic int unsigned qual_load(int unsigned settle, int unsigned stagger,
                                            int unsigned ch);
    return settle + ch * stagger;
  endfunction
endpackage

// File: rtl/fr_sync.sv
module fr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fr_qual.sv
module fr_qual #(
  parameter int unsigned LOAD  = 1,
  parameter int          CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic on,
  input  logic low,
  output logic open_flag
);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD);

  logic [CNT_W-1:0] cnt;

  // Down-counter reloads whenever the channel is off, so every turn-on
  // restarts the full settling window.
  always_ff @(posedge clk) begin
    if (rst || !on)
      cnt <= LOAD_V;
    else if (cnt != '0)
      cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) open_flag <= 1'b0;
    else     open_flag <= on && low && (cnt == '0);
  end
endmodule

// File: rtl/fault_reporter.sv
module fault_reporter #(
  parameter int NUM_CH      = 16,
  parameter int SETTLE_CYC  = 125,
  parameter int STAGGER_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ch_on,
  input  logic [NUM_CH-1:0] ch_low,
  input  logic              hot_in,
  input  logic              blank,
  input  logic              latch_strobe,
  output logic              err_oe_n,
  output logic              err_flag,
  output logic [NUM_CH-1:0] status_open,
  output logic              status_hot
);
  localparam int MAX_LOAD = SETTLE_CYC + (NUM_CH - 1) * STAGGER_CYC;
  localparam int CNT_W    = $clog2(MAX_LOAD + 1);

  logic [NUM_CH-1:0] low_s;
  logic              hot_s;
  logic [NUM_CH-1:0] qual;
  logic              strobe_q;
  logic              err_next;

  fr_sync #(.WIDTH(NUM_CH), .STAGES(2)) u_low_sync (
    .clk(clk), .rst(rst), .d(ch_low), .q(low_s)
  );

  fr_sync #(.WIDTH(1), .STAGES(2)) u_hot_sync (
    .clk(clk), .rst(rst), .d(hot_in), .q(hot_s)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    fr_qual #(
      .LOAD (fr_pkg::qual_load(SETTLE_CYC, STAGGER_CYC, ch)),
      .CNT_W(CNT_W)
    ) u_qual (
      .clk      (clk),
      .rst      (rst),
      .on       (ch_on[ch]),
      .low      (low_s[ch]),
      .open_flag(qual[ch])
    );
  end

  // Thermal faults always reach the pin; open-load faults only when not blanked.
  assign err_next = hot_s | (!blank & (|qual));

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      err_oe_n <= 1'b1;
    end else begin
      err_flag <= err_next;
      err_oe_n <= !err_next;
    end
  end

  // Snapshot on the high-to-low transition of the strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q    <= 1'b0;
      status_open <= '0;
      status_hot  <= 1'b0;
    end else begin
      strobe_q <= latch_strobe;
      if (strobe_q && !latch_strobe) begin
        status_open <= qual;
        status_hot  <= hot_s;
      end
    end
  end
endmodule

// File: rtl/fr_checker.sv
module fr_checker #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ch_on,
  input logic [NUM_CH-1:0] low_s,
  input logic [NUM_CH-1:0] qual,
  input logic              hot_s,
  input logic              blank,
  input logic              strobe_q,
  input logic              latch_strobe,
  input logic              err_flag,
  input logic              err_oe_n,
  input logic [NUM_CH-1:0] status_open,
  input logic              status_hot
);
  logic [NUM_CH-1:0] on_prev;
  logic [NUM_CH-1:0] rose_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_prev <= '0;
      rose_q  <= '0;
    end else begin
      on_prev <= ch_on;
      rose_q  <= ch_on & ~on_prev;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!err_flag && err_oe_n && (status_open == '0) && !status_hot));

  a_r2_no_early_flag: assert property (@(posedge clk) disable iff (rst)
    ((qual & rose_q) == '0));

  a_r3_needs_on_and_low: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((qual & ~$past(ch_on & low_s)) == '0));

  a_r4_off_drops_flag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((qual & ~$past(ch_on)) == '0));

  a_r5_thermal_err: assert property (@(posedge clk) disable iff (rst)
    hot_s |=> err_flag);

  a_r6_blank_quiet: assert property (@(posedge clk) disable iff (rst)
    (!hot_s && (blank || (qual == '0))) |=> !err_flag);

  a_r7_snapshot_hold: assert property (@(posedge clk) disable iff (rst)
    !(strobe_q && !latch_strobe) |=> ($stable(status_open) && $stable(status_hot)));
endmodule

bind fault_reporter fr_checker #(.NUM_CH(NUM_CH)) u_fr_checker (
  .clk         (clk),
  .rst         (rst),
  .ch_on       (ch_on),
  .low_s       (low_s),
  .qual        (qual),
  .hot_s       (hot_s),
  .blank       (blank),
  .strobe_q    (strobe_q),
  .latch_strobe(latch_strobe),
  .err_flag    (err_flag),
  .err_oe_n    (err_oe_n),
  .status_open (status_open),
  .status_hot  (status_hot)
);

// File: tb/test_fault_reporter.sv
`timescale 1ns/1ps
module test_fault_reporter;
  localparam int NUM_CH  = 16;
  localparam int SETTLE  = 6;
  localparam int STAGGER = 2;
  localparam int LOAD0   = SETTLE;
  localparam int LOAD15  = SETTLE + 15 * STAGGER;
  localparam int NVEC    = 8;

  // {on[15:0], low[15:0], hot, blank, expected err}
  localparam logic [34:0] VEC [NVEC] = '{
    {16'h0000, 16'hFFFF, 1'b0, 1'b0, 1'b0},
    {16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h0001, 16'h0001, 1'b0, 1'b0, 1'b1},
    {16'h8000, 16'h8000, 1'b0, 1'b1, 1'b0},
    {16'h00F0, 16'h0F00, 1'b0, 1'b0, 1'b0},
    {16'h0000, 16'h0000, 1'b1, 1'b0, 1'b1},
    {16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1},
    {16'hA5A5, 16'hFFFF, 1'b0, 1'b0, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic [NUM_CH-1:0] ch_on;
  logic [NUM_CH-1:0] ch_low;
  logic              hot_in;
  logic              blank;
  logic              latch_strobe;
  logic              err_oe_n;
  logic              err_flag;
  logic [NUM_CH-1:0] status_open;
  logic              status_hot;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  fault_reporter #(
    .NUM_CH(NUM_CH), .SETTLE_CYC(SETTLE), .STAGGER_CYC(STAGGER)
  ) i_fault_reporter (
    .clk(clk), .rst(rst), .ch_on(ch_on), .ch_low(ch_low), .hot_in(hot_in),
    .blank(blank), .latch_strobe(latch_strobe), .err_oe_n(err_oe_n),
    .err_flag(err_flag), .status_open(status_open), .status_hot(status_hot)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_strobe();
    latch_strobe = 1'b1;
    tick(1);
    latch_strobe = 1'b0;
    tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v_on, v_low;
    logic        v_hot, v_blank, v_exp;
    rst = 1'b1; ch_on = '0; ch_low = '0; hot_in = 1'b0; blank = 1'b0; latch_strobe = 1'b0;
    tick(3);
    check("R1 err_flag in reset", 32'(err_flag), 32'd0);
    check("R1 err_oe_n in reset", 32'(err_oe_n), 32'd1);
    rst = 1'b0;
    tick(1);
    check("R1 status_open after reset", 32'(status_open), 32'd0);
    check("R1 status_hot after reset", 32'(status_hot), 32'd0);

    // Steady-state table walk
    for (int v = 0; v < NVEC; v++) begin
      {v_on, v_low, v_hot, v_blank, v_exp} = VEC[v];
      ch_on = v_on; ch_low = v_low; hot_in = v_hot; blank = v_blank;
      tick(60);
      check($sformatf("R3/R6 table vector %0d err_flag", v), 32'(err_flag), 32'(v_exp));
      check($sformatf("R9 table vector %0d err_oe_n", v), 32'(err_oe_n), 32'(!v_exp));
      pulse_strobe();
      check($sformatf("R7 table vector %0d status_open", v), 32'(status_open), 32'(v_on & v_low));
      check($sformatf("R7 table vector %0d status_hot", v), 32'(status_hot), 32'(v_hot));
    end

    // Low everywhere but nothing on
    ch_on = '0; ch_low = 16'hFFFF; hot_in = 1'b0; blank = 1'b0;
    tick(5);
    check("R3 low while off", 32'(err_flag), 32'd0);

    // Channel 0 window
    ch_on = 16'h0001;
    tick(LOAD0 + 1);
    check("R2 channel 0 not early", 32'(err_flag), 32'd0);
    tick(1);
    check("R2 channel 0 at window", 32'(err_flag), 32'd1);
    check("R9 pull-down enabled", 32'(err_oe_n), 32'd0);

    // Turn-off and restart
    ch_on = '0;
    tick(1);
    check("R4 error one edge after off", 32'(err_flag), 32'd1);
    tick(1);
    check("R4 error two edges after off", 32'(err_flag), 32'd0);
    ch_on = 16'h0001;
    tick(LOAD0 + 1);
    check("R4 restarted window not early", 32'(err_flag), 32'd0);
    tick(1);
    check("R4 restarted window at end", 32'(err_flag), 32'd1);
    ch_on = '0;
    tick(3);

    // Channel 15 stagger
    ch_on = 16'h8000;
    tick(LOAD15 + 1);
    check("R8 channel 15 not early", 32'(err_flag), 32'd0);
    tick(1);
    check("R8 channel 15 at window", 32'(err_flag), 32'd1);

    // Blank masking
    blank = 1'b1;
    tick(1);
    check("R6 blank masks open-load", 32'(err_flag), 32'd0);
    hot_in = 1'b1;
    tick(3);
    check("R6 blank keeps thermal", 32'(err_flag), 32'd1);
    hot_in = 1'b0;
    tick(3);
    check("R6 blank thermal cleared", 32'(err_flag), 32'd0);

    // Snapshot edges (last capture was vector 7: A5A5)
    latch_strobe = 1'b1;
    tick(4);
    check("R7 no capture on rise or high", 32'(status_open), 32'hA5A5);
    latch_strobe = 1'b0;
    tick(1);
    check("R7 capture on fall under blank", 32'(status_open), 32'h8000);
    check("R7 capture thermal clear", 32'(status_hot), 32'd0);
    hot_in = 1'b1;
    tick(3);
    pulse_strobe();
    check("R7 capture thermal set", 32'(status_hot), 32'd1);
    hot_in = 1'b0;
    tick(4);
    check("R7 snapshot held while idle", 32'(status_hot), 32'd1);

    // Thermal latency and no latching
    blank = 1'b0; ch_on = '0;
    tick(3);
    hot_in = 1'b1;
    tick(2);
    check("R5 thermal not early", 32'(err_flag), 32'd0);
    tick(1);
    check("R5 thermal at third edge", 32'(err_flag), 32'd1);
    hot_in = 1'b0;
    tick(2);
    check("R5 thermal still shown", 32'(err_flag), 32'd1);
    tick(1);
    check("R5 thermal clears without latch", 32'(err_flag), 32'd0);

    // Reset in the middle of a fault
    hot_in = 1'b1;
    tick(5);
    rst = 1'b1; hot_in = 1'b0;
    tick(1);
    check("R1 mid-run reset err_flag", 32'(err_flag), 32'd0);
    check("R1 mid-run reset err_oe_n", 32'(err_oe_n), 32'd1);
    check("R1 mid-run reset status_open", 32'(status_open), 32'd0);
    check("R1 mid-run reset status_hot", 32'(status_hot), 32'd0);
    rst = 1'b0;
    tick(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule